// File: doc/BRIEF.md
# Branch Hint Trust Monitor

This block decides whether a core can keep trusting branch predictions from a predictor trained by hints. The hints come from a companion core that runs ahead of it. Two predictors run side by side on the consuming core: its own baseline predictor and the hint-trained one. Each time a branch resolves, the branch unit pulses a strobe and reports whether each predictor was correct.

The block keeps a saturating trust counter:

- It moves up when only the hint-trained predictor was wrong.
- It moves down when only the baseline was wrong.
- It holds when both predictors agree on correctness.

When a resolve strobe leaves the counter above a programmable threshold, the block raises a disable flag. From then on, every prediction comes from the baseline predictor. The disable is coarse and sticky: it applies to all branches and stays set until a resync pulse. The resync pulse clears the counter and turns hints back on. The block also contains the final prediction multiplexer, so the consumer sees one prediction bit and a flag that names its source.

Top module: `bhint_trust_mon`

## Requirements
- R1: After reset, hint_off is 0, src_is_hint is 1 and the trust counter is 0.
- R2: A cycle with resolve_vld=1, base_ok=1 and hint_ok=0 raises the trust counter by one.
- R3: A cycle with resolve_vld=1, base_ok=0 and hint_ok=1 lowers the trust counter by one.
- R4: The trust counter holds when resolve_vld=1 and base_ok equals hint_ok, and in any cycle with resolve_vld=0.
- R5: The trust counter saturates at both ends. It stays at 2^CNT_W-1 on a further raise and at 0 on a further lowering.
- R6: hint_off is set at the clock edge that samples a resolve strobe whose updated counter value is strictly greater than thresh. It is visible from the following cycle. The threshold is compared only at resolve strobes.
- R7: Once set, hint_off stays 1 until a resync pulse, whatever the later branch outcomes are.
- R8: A resync pulse clears the counter and hint_off at the next edge. It overrides a resolve strobe presented in the same cycle.
- R9: src_is_hint is the inverse of hint_off. pred_taken equals hint_taken when src_is_hint=1 and base_taken otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| resolve_vld | input | 1 | A branch resolved this cycle |
| base_ok | input | 1 | Baseline predictor was correct for that branch |
| hint_ok | input | 1 | Hint-trained predictor was correct for that branch |
| thresh | input | CNT_W | Disable threshold (strict greater-than) |
| resync | input | 1 | Clears the counter and re-enables hints |
| base_taken | input | 1 | Current baseline prediction |
| hint_taken | input | 1 | Current hint-trained prediction |
| hint_off | output | 1 | Branch hints are disabled |
| src_is_hint | output | 1 | The selected prediction comes from the hint predictor |
| pred_taken | output | 1 | Selected prediction |

## Verification
A resync pulse and a resolve strobe can fall in the same cycle. This includes a resolve strobe that would carry the counter over the threshold. The bench provokes this in three ways:

- It brings the counter one step below the threshold and presents a raising outcome together with resync.
- It presents resync while hints are already off.
- It sprinkles resync pulses randomly among resolve traffic.

The behavioural model gives resync priority. A resolve swallowed this way must leave no trace: the bench judges this through the later timing of hint_off, which must match a counter that restarted from zero.

// File: rtl/bhint_trust_mon.sv
module bhint_trust_mon #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resolve_vld,
  input  logic             base_ok,
  input  logic             hint_ok,
  input  logic [CNT_W-1:0] thresh,
  input  logic             resync,
  input  logic             base_taken,
  input  logic             hint_taken,
  output logic             hint_off,
  output logic             src_is_hint,
  output logic             pred_taken
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             off_q;
  logic             up, dn;

  assign up = resolve_vld &  base_ok & ~hint_ok;
  assign dn = resolve_vld & ~base_ok &  hint_ok;

  always_comb begin
    cnt_nxt = cnt_q;
    if (up && cnt_q != CNT_MAX) cnt_nxt = cnt_q + 1'b1;
    else if (dn && cnt_q != '0) cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      off_q <= 1'b0;
    end else if (resync) begin
      cnt_q <= '0;
      off_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (resolve_vld && cnt_nxt > thresh) off_q <= 1'b1;
    end
  end

  assign hint_off    = off_q;
  assign src_is_hint = ~off_q;
  assign pred_taken  = off_q ? base_taken : hint_taken;
endmodule

module bhint_trust_mon_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             resolve_vld,
  input logic             base_ok,
  input logic             hint_ok,
  input logic             resync,
  input logic [CNT_W-1:0] thresh,
  input logic [CNT_W-1:0] cnt_q,
  input logic             hint_off
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R2
  raise_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_vld && base_ok && !hint_ok && !resync && cnt_q != CNT_MAX)
      |=> cnt_q == $past(cnt_q) + 1'b1);

  // R3
  lower_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_vld && !base_ok && hint_ok && !resync && cnt_q != '0)
      |=> cnt_q == $past(cnt_q) - 1'b1);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!resync && (!resolve_vld || base_ok == hint_ok)) |=> $stable(cnt_q));

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !resync) |=> cnt_q == CNT_MAX || cnt_q == CNT_MAX - 1'b1);

  // R6
  off_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hint_off) |-> $past(resolve_vld) && cnt_q > $past(thresh));

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hint_off && !resync) |=> hint_off);

  // R8
  resync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (!hint_off && cnt_q == '0));
endmodule

bind bhint_trust_mon bhint_trust_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .resolve_vld(resolve_vld), .base_ok(base_ok),
  .hint_ok(hint_ok), .resync(resync), .thresh(thresh), .cnt_q(cnt_q),
  .hint_off(hint_off)
);

// File: tb/sim_bhint_trust_mon.sv
module sim_bhint_trust_mon;
  logic       clk = 0, rst_n = 0;
  logic       resolve_vld = 0, base_ok = 0, hint_ok = 0, resync = 0;
  logic [7:0] thresh = 8'd3;
  logic       base_taken = 0, hint_taken = 0;
  logic       hint_off, src_is_hint, pred_taken;

  int    vecs = 0, errs = 0;
  int    m_cnt = 0;
  bit    m_off = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  bhint_trust_mon u0 (.*);

  // reference model
  always @(posedge clk) begin
    if (rst_n) begin
      if (resync) begin
        m_cnt = 0; m_off = 0;
      end else begin
        if (resolve_vld && base_ok && !hint_ok && m_cnt < 255) m_cnt++;
        else if (resolve_vld && !base_ok && hint_ok && m_cnt > 0) m_cnt--;
        if (resolve_vld && m_cnt > int'(thresh)) m_off = 1;
      end
    end
  end

  task automatic check_outs();
    bit exp_pred;
    exp_pred = m_off ? base_taken : hint_taken;
    vecs++;
    if (hint_off !== m_off) begin
      errs++;
      $display("FAIL %s hint_off got %0b exp %0b", tag, hint_off, m_off);
    end
    // R9
    if (src_is_hint !== !m_off || pred_taken !== exp_pred) begin
      errs++;
      $display("FAIL R9 src/pred got %0b/%0b exp %0b/%0b",
               src_is_hint, pred_taken, !m_off, exp_pred);
    end
  endtask

  task automatic step(input bit v, input bit b, input bit h, input bit rs);
    @(negedge clk);
    check_outs();
    resolve_vld = v; base_ok = b; hint_ok = h; resync = rs;
    base_taken = $urandom; hint_taken = $urandom;
  endtask

  task automatic repeat_step(input int n, input bit v, input bit b, input bit h);
    for (int i = 0; i < n; i++) step(v, b, h, 0);
  endtask

  initial begin
    #2000000;
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; step(0, 0, 0, 0); step(0, 0, 0, 0);
    // R2, R6: threshold 3, four raises disable
    tag = "R2"; repeat_step(3, 1, 1, 0);
    tag = "R6"; step(1, 1, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    // R7: sticky despite lowering
    tag = "R7"; repeat_step(10, 1, 0, 1); step(0, 0, 0, 0);
    // R8: resync clears
    tag = "R8"; step(0, 0, 0, 1); step(0, 0, 0, 0); step(0, 0, 0, 0);
    // R3, R5: lower at zero saturates, then raises
    tag = "R5"; repeat_step(5, 1, 0, 1);
    tag = "R3"; repeat_step(3, 1, 1, 0); repeat_step(2, 1, 0, 1);
    repeat_step(3, 1, 1, 0); step(0, 0, 0, 0);
    // R4: agreement and idle cycles hold
    tag = "R4"; step(0, 0, 0, 1); repeat_step(2, 1, 1, 0);
    repeat_step(6, 1, 1, 1); repeat_step(6, 1, 0, 0); repeat_step(4, 0, 1, 0);
    step(1, 1, 0, 0); step(1, 1, 0, 0); step(0, 0, 0, 0);
    // R6: threshold only compared at resolve
    tag = "R6"; step(0, 0, 0, 1); repeat_step(2, 1, 1, 0);
    thresh = 8'd1; repeat_step(3, 0, 0, 0); step(1, 1, 1, 0); step(0, 0, 0, 0);
    // R8: resync wins over same-cycle crossing raise
    tag = "R8"; step(0, 0, 0, 1); thresh = 8'd2; repeat_step(2, 1, 1, 0);
    step(1, 1, 0, 1); step(0, 0, 0, 0); repeat_step(2, 1, 1, 0); step(0, 0, 0, 0);
    // R6: threshold zero
    tag = "R6"; step(0, 0, 0, 1); thresh = 8'd0; step(1, 1, 0, 0); step(0, 0, 0, 0);
    // R5: upper saturation with max threshold never disables
    tag = "R5"; step(0, 0, 0, 1); thresh = 8'hFF;
    repeat_step(300, 1, 1, 0); step(1, 0, 1, 0); step(0, 0, 0, 0);
    // R9 and mixed traffic
    tag = "R7"; thresh = 8'd5;
    for (int i = 0; i < 3000; i++) step($urandom, $urandom, $urandom, ($urandom % 97) == 0);
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule